// File: doc/BRIEF.md
# Multi-channel RGB gamma lookup table

This block applies gamma correction to pixels coming from several display channels through one shared table memory. Each pixel carries 8-bit red, green and blue components and a channel number. Each component is remapped through its own 256-entry, 8-bit table that belongs to that channel. The lookup takes one clock cycle, and a valid flag travels with the pixel. A per-channel enable vector chooses between the table and a straight pass-through. Both paths have the same latency, so the pixel stream keeps its timing when a channel switches mode.

A host loads the memory through two write strobes. The first loads a pointer register together with an auto-increment flag. The second writes one byte at the pointer. The memory is one flat array in which every channel owns a block of three consecutive 256-byte tables: red, then green, then blue. A host can therefore load a whole channel with one pointer write followed by 768 data writes. Host writes and pixel lookups can happen in the same cycle.

Top module: `gamma_lut`

## Requirements
- R1: After reset every table entry holds its own index (entry i of every table reads back as i), the pointer is 0, auto-increment is off, and pix_valid_o is 0.
- R2: The byte for channel c, component k (red 0, green 1, blue 2) and input value v is at address c*768 + k*256 + v. A lookup replaces each component with the entry at that address, selected by that component's own input value.
- R3: When auto-increment is on, a data write stores the byte at the pointer and then adds one to the pointer, wrapping at the pointer width (12 bits for 3 channels).
- R4: When auto-increment is off, data writes store at the pointer and leave the pointer unchanged.
- R5: A pointer write loads both the pointer and the auto-increment flag. A data write in the same cycle uses the old pointer, and the new pointer value takes precedence over the increment. A data write at an address of NUM_CH*768 or above is dropped.
- R6: pix_valid_o equals pix_valid_i delayed by exactly one cycle. The pixel data is valid in that same cycle.
- R7: A pixel whose channel has gamma_en_i[ch]=0, or whose channel number is NUM_CH or greater, leaves the block unchanged with the same one-cycle latency.
- R8: A lookup in the same cycle as a write to the entry it reads returns the old entry. Later lookups return the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ptr_we_i | input | 1 | Load pointer and auto-increment flag |
| ptr_i | input | 12 | New pointer value |
| ptr_inc_i | input | 1 | New auto-increment flag |
| data_we_i | input | 1 | Write one byte at the pointer |
| data_i | input | 8 | Byte to write |
| gamma_en_i | input | 3 | Per-channel table enable |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_ch_i | input | 2 | Input pixel channel |
| pix_r_i | input | 8 | Input red |
| pix_g_i | input | 8 | Input green |
| pix_b_i | input | 8 | Input blue |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_r_o | output | 8 | Output red |
| pix_g_o | output | 8 | Output green |
| pix_b_o | output | 8 | Output blue |

## Verification
The assertions assume that gamma_en_i and the host strobes are defined from the first cycle after reset. They also assume that the table enable of a channel stays steady for the whole cycle of a lookup. The bench drives every input at the falling edge, holds it through the next rising edge, and keeps the enable vector constant within each stimulus phase. The write-ordering checks expect that nothing changes the pointer except the two strobes. The bench sends every pointer write through the same interface that the reference model follows.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
  localparam int unsigned COMP_W   = 8;
  localparam int unsigned COMP_N   = 3;
  localparam int unsigned TBL_SIZE = 1 << COMP_W;
  localparam int unsigned BLK_SIZE = COMP_N * TBL_SIZE;

  typedef enum logic [1:0] {COMP_R = 2'd0, COMP_G = 2'd1, COMP_B = 2'd2} comp_e;
  typedef logic [COMP_W-1:0] comp_t;
endpackage

// File: rtl/gamma_lut_ptr.sv
module gamma_lut_ptr #(
  parameter int unsigned AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ptr_we_i,
  input  logic [AW-1:0] ptr_i,
  input  logic          ptr_inc_i,
  input  logic          data_we_i,
  output logic [AW-1:0] ptr_o
);
  logic inc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o <= '0;
      inc_q <= 1'b0;
    end else if (ptr_we_i) begin
      ptr_o <= ptr_i;
      inc_q <= ptr_inc_i;
    end else if (data_we_i && inc_q) begin
      ptr_o <= ptr_o + AW'(1);
    end
  end

  assert_ptr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we_i && !ptr_we_i && inc_q) |=> ptr_o == $past(ptr_o) + AW'(1));
  assert_ptr_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we_i && !ptr_we_i && !inc_q) |=> $stable(ptr_o));
  assert_ptr_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_we_i |=> ptr_o == $past(ptr_i));
endmodule

// File: rtl/gamma_lut_table.sv
module gamma_lut_table
  import gamma_lut_pkg::*;
#(
  parameter int unsigned DEPTH = 768,
  parameter int unsigned AW    = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  comp_t         wdata_i,
  input  logic [AW-1:0] raddr_i [COMP_N],
  output comp_t         rdata_o [COMP_N]
);
  comp_t mem [DEPTH];
  logic  wr_ok;

  assign wr_ok = we_i && ({1'b0, waddr_i} < (AW+1)'(DEPTH));

  // reset contents form the identity ramp per 256-entry table
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= COMP_W'(i);
    end else if (wr_ok) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  for (genvar c = 0; c < COMP_N; c++) begin : g_rd
    assign rdata_o[c] = mem[raddr_i[c]];
  end

  assert_write_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok |=> mem[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/gamma_lut.sv
module gamma_lut
  import gamma_lut_pkg::*;
#(
  parameter int unsigned NUM_CH = 3,
  localparam int unsigned DEPTH = NUM_CH * BLK_SIZE,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ptr_we_i,
  input  logic [AW-1:0]     ptr_i,
  input  logic              ptr_inc_i,
  input  logic              data_we_i,
  input  logic [COMP_W-1:0] data_i,
  input  logic [NUM_CH-1:0] gamma_en_i,
  input  logic              pix_valid_i,
  input  logic [CHW-1:0]    pix_ch_i,
  input  logic [COMP_W-1:0] pix_r_i,
  input  logic [COMP_W-1:0] pix_g_i,
  input  logic [COMP_W-1:0] pix_b_i,
  output logic              pix_valid_o,
  output logic [COMP_W-1:0] pix_r_o,
  output logic [COMP_W-1:0] pix_g_o,
  output logic [COMP_W-1:0] pix_b_o
);
  localparam int unsigned EN_W = 1 << CHW;

  logic [AW-1:0]   ptr;
  logic [AW-1:0]   rd_addr [COMP_N];
  comp_t           rd_data [COMP_N];
  comp_t           comp_in [COMP_N];
  comp_t           comp_q  [COMP_N];
  logic [EN_W-1:0] en_ext;
  logic [AW-1:0]   ch_base;
  logic            use_lut;
  logic            valid_q;

  gamma_lut_ptr #(.AW(AW)) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ptr_we_i (ptr_we_i),
    .ptr_i    (ptr_i),
    .ptr_inc_i(ptr_inc_i),
    .data_we_i(data_we_i),
    .ptr_o    (ptr)
  );

  gamma_lut_table #(.DEPTH(DEPTH), .AW(AW)) u_table (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (data_we_i),
    .waddr_i(ptr),
    .wdata_i(data_i),
    .raddr_i(rd_addr),
    .rdata_o(rd_data)
  );

  assign comp_in[0] = pix_r_i;
  assign comp_in[1] = pix_g_i;
  assign comp_in[2] = pix_b_i;

  // channels beyond NUM_CH read a zero enable and bypass
  assign en_ext  = EN_W'(gamma_en_i);
  assign use_lut = en_ext[pix_ch_i];
  assign ch_base = AW'(pix_ch_i) * AW'(BLK_SIZE);

  for (genvar c = 0; c < COMP_N; c++) begin : g_comp
    assign rd_addr[c] = ch_base + AW'(c * TBL_SIZE) + AW'(comp_in[c]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          comp_q[c] <= '0;
      else if (pix_valid_i) comp_q[c] <= use_lut ? rd_data[c] : comp_in[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= pix_valid_i;
  end

  assign pix_valid_o = valid_q;
  assign pix_r_o     = comp_q[0];
  assign pix_g_o     = comp_q[1];
  assign pix_b_o     = comp_q[2];

  assert_valid_on_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_i |=> pix_valid_o);
  assert_valid_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_i |=> !pix_valid_o);
  assert_bypass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && !use_lut) |=>
      (pix_r_o == $past(pix_r_i) && pix_g_o == $past(pix_g_i) && pix_b_o == $past(pix_b_i)));
  assert_hold_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_i |=> (pix_r_o == $past(pix_r_o) && pix_b_o == $past(pix_b_o)));
endmodule

// File: tb/gamma_lut_bench.sv
module gamma_lut_bench;
  localparam int NUM_CH = 3;
  localparam int DEPTH  = NUM_CH * 768;
  localparam int AW     = 12;

  logic clk = 0, rst_n = 0;
  logic ptr_we = 0, ptr_inc = 0, data_we = 0, pix_valid = 0;
  logic [AW-1:0] ptr_v = '0;
  logic [7:0] data_v = '0, pr = '0, pg = '0, pb = '0;
  logic [NUM_CH-1:0] gen = '1;
  logic [1:0] pch = '0;
  logic vo;
  logic [7:0] ro, go, bo;

  int errors = 0, checks = 0, cycles = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  gamma_lut #(.NUM_CH(NUM_CH)) u_gamma_lut (
    .clk_i(clk), .rst_ni(rst_n), .ptr_we_i(ptr_we), .ptr_i(ptr_v), .ptr_inc_i(ptr_inc),
    .data_we_i(data_we), .data_i(data_v), .gamma_en_i(gen), .pix_valid_i(pix_valid),
    .pix_ch_i(pch), .pix_r_i(pr), .pix_g_i(pg), .pix_b_i(pb),
    .pix_valid_o(vo), .pix_r_o(ro), .pix_g_o(go), .pix_b_o(bo));

  // reference model
  byte unsigned mdl [DEPTH];
  int  maddr;
  bit  minc;
  bit  ev;
  byte unsigned er, eg, eb;

  function automatic byte unsigned look(int ch, int k, byte unsigned v);
    if (ch >= NUM_CH || !gen[ch]) return v;
    return mdl[ch * 768 + k * 256 + v];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mdl[i] = byte'(i % 256);
      maddr = 0; minc = 0; ev = 0; er = 0; eg = 0; eb = 0;
    end else begin
      ev = pix_valid;
      if (pix_valid) begin
        er = look(pch, 0, pr);
        eg = look(pch, 1, pg);
        eb = look(pch, 2, pb);
      end
      if (data_we && maddr < DEPTH) mdl[maddr] = data_v;
      if (ptr_we) begin
        maddr = ptr_v; minc = ptr_inc;
      end else if (data_we && minc) maddr = (maddr + 1) % (1 << AW);
    end
  end

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(vo == ev, "valid", vo, ev);
    if (ev) begin
      chk(ro == er, "red", ro, er);
      chk(go == eg, "green", go, eg);
      chk(bo == eb, "blue", bo, eb);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic idle();
    @(negedge clk);
    ptr_we = 0; data_we = 0; pix_valid = 0;
  endtask

  task automatic set_ptr(int a, bit inc);
    @(negedge clk);
    ptr_we = 1; ptr_v = AW'(a); ptr_inc = inc; data_we = 0; pix_valid = 0;
  endtask

  task automatic wr(byte unsigned d);
    @(negedge clk);
    ptr_we = 0; data_we = 1; data_v = d; pix_valid = 0;
  endtask

  task automatic px(int ch, byte unsigned r, byte unsigned g, byte unsigned b);
    @(negedge clk);
    ptr_we = 0; data_we = 0; pix_valid = 1; pch = 2'(ch); pr = r; pg = g; pb = b;
  endtask

  task automatic sweep();
    for (int c = 0; c < 4; c++)
      for (int v = 0; v < 256; v += 17) px(c, byte'(v), byte'(255 - v), byte'(v * 3));
  endtask

  initial begin
    #1;
    checks++;
    if (vo !== 1'b0) begin errors++; $display("FAIL R1 reset valid: actual=%0b expected=0", vo); end
    repeat (3) @(negedge clk);
    rst_n = 1;
    checks++;
    if (vo !== 1'b0) begin errors++; $display("FAIL R1 post-reset valid: actual=%0b expected=0", vo); end

    cur_req = "R1"; sweep(); idle();

    cur_req = "R2"; set_ptr(768, 1);
    for (int i = 0; i < 768; i++) wr(byte'((i * 7) ^ 8'h5a));
    idle(); sweep(); idle();

    cur_req = "R3"; set_ptr(2 * 768 + 256 + 40, 1);
    for (int i = 0; i < 5; i++) wr(byte'(200 + i));
    idle(); for (int v = 38; v < 48; v++) px(2, 0, byte'(v), 0); idle();

    cur_req = "R4"; set_ptr(10, 0);
    wr(8'h11); wr(8'h22); wr(8'h33); idle();
    px(0, 10, 11, 10); px(0, 9, 10, 11); idle();

    cur_req = "R5"; set_ptr(20, 1);
    @(negedge clk); ptr_we = 1; ptr_v = 12'd30; ptr_inc = 1; data_we = 1; data_v = 8'h77; pix_valid = 0;
    wr(8'h88); idle();
    set_ptr(4094, 1); wr(8'hd1); wr(8'hd2); wr(8'hd3); wr(8'hd4); idle();
    set_ptr(DEPTH, 0); wr(8'hee); idle();
    for (int v = 0; v < 32; v++) px(0, byte'(v), byte'(v), byte'(v)); idle();

    cur_req = "R7"; gen = 3'b101; sweep(); idle();
    gen = 3'b000; sweep(); idle(); gen = 3'b111;

    cur_req = "R8"; set_ptr(768 + 100, 1);
    @(negedge clk); ptr_we = 0; data_we = 1; data_v = 8'hab; pix_valid = 1; pch = 1; pr = 100; pg = 0; pb = 0;
    @(negedge clk); data_we = 0; pix_valid = 1; pr = 100;
    idle();

    cur_req = "R6";
    for (int i = 0; i < 40; i++) begin
      if (i % 3 == 0) idle(); else px(i % 3, byte'(i * 5), byte'(i), byte'(i * 9));
    end
    idle(); idle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule